// File: doc/BRIEF.md
# I2C Master Start-Condition Sequencer

This block produces the Start condition of an I2C bus master. Software sets a start-request bit in a small control register. The block then checks that both bus lines are idle. It times two equal intervals with a reloadable baud-rate down-counter. At the end of the first interval it pulls SDA low while SCL stays released, which forms the Start. At the end of the second interval it retires the request and raises a completion interrupt. SDA then stays held low, ready for the first bit.

Both bus inputs pass through a two-flop synchronizer before the sequencer samples them. SDA is driven only through an open-drain output enable, never high. If the bus is not free at the request, or if SCL falls before SDA has been pulled low, the block flags a bus collision, drops the request and goes back to idle. While a sequence is running, a write to the transmit buffer is refused and raises a write-collision flag. Writes to the control register are dropped during that time, so no second bus event can be queued behind the Start.

Top module: `i2c_start_seq`

## Requirements
- R1: After reset, `sda_oe`, `ctrl_q`, `start_seen`, `done_irq`, `bcol_irq`, `wcol_flag` and `buf_q` are all zero.
- R2: With both lines high, a request (control bit 0 written as 1 from idle) loads the counter. `sda_oe` and `start_seen` go to 1 exactly after N asserted `tick` cycles, where N is the effective reload value.
- R3: Exactly N further `tick` cycles after SDA is pulled low, `done_irq` is set and control bit 0 is cleared by hardware.
- R4: After completion the counter is suspended. `sda_oe` stays 1 and no further status changes, however many ticks arrive.
- R5: The effective reload value N is `max(reload, 1)`. A reload of 0 or 1 gives one tick per phase.
- R6: If either synchronized line is low when the request is seen, `bcol_irq` is set, control bit 0 is cleared and `sda_oe` stays 0.
- R7: If synchronized SCL is low during the first phase, the sequence aborts: `bcol_irq` is set, control bit 0 is cleared, `sda_oe` stays 0, and no Start follows later.
- R8: A `buf_wr` while a sequence runs sets `wcol_flag` and leaves `buf_q` unchanged. Outside a sequence it loads `buf_q`.
- R9: A `ctrl_wr` while a sequence runs leaves all bits of `ctrl_q` unchanged, apart from the hardware clear of bit 0.
- R10: `done_irq`, `bcol_irq` and `wcol_flag` are sticky. They clear only when software pulses `irq_clr` bit 0, bit 1 or bit 2 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Baud counter clock enable |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control write data; bit 0 requests a Start |
| reload | input | 7 | Baud counter reload value |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Transmit buffer write data |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| irq_clr | input | 3 | Clear strobes: bit0 done, bit1 bus collision, bit2 write collision |
| sda_oe | output | 1 | Pull SDA low when 1 |
| ctrl_q | output | 5 | Control register contents |
| start_seen | output | 1 | Start condition issued |
| done_irq | output | 1 | Sticky completion interrupt |
| bcol_irq | output | 1 | Sticky bus-collision interrupt |
| wcol_flag | output | 1 | Sticky write-collision flag |
| buf_q | output | 8 | Transmit buffer contents |

## Verification
The timed sequence runs with `tick` held high and with sparse random ticks. These runs separate a counter that counts clock enables from one that counts clock cycles. Reload values of 0, 1 and several random values up to 19 check the minimum-count clamp and the phase-length equality. Collision runs hold both lines low, hold only SDA low, and drop SCL mid-phase, which covers both abort paths. Writes to the buffer and to the control register are made once during a running sequence and once outside it, so that refusal and acceptance are both observed.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

    localparam int RELOAD_W_DEF = 7;
    localparam int CTRL_W_DEF   = 5;
    localparam int DATA_W_DEF   = 8;
    localparam int SYNC_N_DEF   = 2;

    localparam int START_BIT = 0;
    localparam int IRQ_DONE  = 0;
    localparam int IRQ_BCOL  = 1;
    localparam int IRQ_WCOL  = 2;
    localparam int IRQ_N     = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PH1  = 2'd1,
        ST_PH2  = 2'd2,
        ST_HOLD = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic sda;
        logic scl;
    } bus_lines_t;

    function automatic logic bus_free(input bus_lines_t b);
        return b.sda && b.scl;
    endfunction

endpackage

// File: rtl/i2c_start_sync.sv
module i2c_start_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '1;
                else     stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '1;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_start_brg.sv
module i2c_start_brg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic         stop,
    input  logic [W-1:0] reload,
    output logic         timeout
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic [W-1:0] eff;

    assign eff     = (reload <= ONE) ? ONE : reload;
    assign timeout = tick && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= eff;
        else if (stop)             cnt <= '0;
        else if (tick && cnt != 0) cnt <= cnt - ONE;
    end

    a_r5_min_count: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt != '0));
endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
    import i2c_start_pkg::*;
#(
    parameter int RELOAD_W = RELOAD_W_DEF,
    parameter int CTRL_W   = CTRL_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int SYNC_N   = SYNC_N_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                ctrl_wr,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                buf_wr,
    input  logic [DATA_W-1:0]   buf_wdata,
    input  logic                sda_in,
    input  logic                scl_in,
    input  logic [IRQ_N-1:0]    irq_clr,
    output logic                sda_oe,
    output logic [CTRL_W-1:0]   ctrl_q,
    output logic                start_seen,
    output logic                done_irq,
    output logic                bcol_irq,
    output logic                wcol_flag,
    output logic [DATA_W-1:0]   buf_q
);
    seq_state_e state, nxt;
    bus_lines_t bus_s;
    logic       busy, timeout;
    logic       brg_load, brg_stop, drive_low;
    logic       set_seen, set_done, set_bcol, clr_en;

    i2c_start_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sda_in, scl_in}),
        .q   ({bus_s.sda, bus_s.scl})
    );

    i2c_start_brg #(.W(RELOAD_W)) u_brg (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (brg_load),
        .stop    (brg_stop),
        .reload  (reload),
        .timeout (timeout)
    );

    assign busy = (state == ST_PH1) || (state == ST_PH2);

    always_comb begin
        nxt       = state;
        brg_load  = 1'b0;
        brg_stop  = 1'b0;
        drive_low = 1'b0;
        set_seen  = 1'b0;
        set_done  = 1'b0;
        set_bcol  = 1'b0;
        clr_en    = 1'b0;
        unique case (state)
            ST_IDLE: if (ctrl_q[START_BIT]) begin
                if (bus_free(bus_s)) begin
                    brg_load = 1'b1;
                    nxt      = ST_PH1;
                end else begin
                    set_bcol = 1'b1;
                    clr_en   = 1'b1;
                end
            end
            ST_PH1: begin
                if (!bus_s.scl || (timeout && !bus_free(bus_s))) begin
                    set_bcol = 1'b1;
                    clr_en   = 1'b1;
                    brg_stop = 1'b1;
                    nxt      = ST_IDLE;
                end else if (timeout) begin
                    drive_low = 1'b1;
                    set_seen  = 1'b1;
                    brg_load  = 1'b1;
                    nxt       = ST_PH2;
                end
            end
            ST_PH2: if (timeout) begin
                set_done = 1'b1;
                clr_en   = 1'b1;
                nxt      = ST_HOLD;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            sda_oe     <= 1'b0;
            start_seen <= 1'b0;
            ctrl_q     <= '0;
            done_irq   <= 1'b0;
            bcol_irq   <= 1'b0;
            wcol_flag  <= 1'b0;
            buf_q      <= '0;
        end else begin
            state <= nxt;
            if (drive_low) sda_oe     <= 1'b1;
            if (set_seen)  start_seen <= 1'b1;
            if (ctrl_wr && !busy) ctrl_q <= ctrl_wdata;
            if (clr_en) ctrl_q[START_BIT] <= 1'b0;
            done_irq  <= set_done | (done_irq & ~irq_clr[IRQ_DONE]);
            bcol_irq  <= set_bcol | (bcol_irq & ~irq_clr[IRQ_BCOL]);
            wcol_flag <= (buf_wr && busy) | (wcol_flag & ~irq_clr[IRQ_WCOL]);
            if (buf_wr && !busy) buf_q <= buf_wdata;
        end
    end

    a_r6_abort_releases: assert property (@(posedge clk) disable iff (rst)
        $rose(bcol_irq) |-> (!sda_oe && !ctrl_q[START_BIT]));

    a_r3_done_clears_req: assert property (@(posedge clk) disable iff (rst)
        $rose(done_irq) |-> !ctrl_q[START_BIT]);

    a_r4_hold_low: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |=> (sda_oe && state == ST_HOLD));

    a_r8_buf_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && buf_wr) |=> (wcol_flag && $stable(buf_q)));

    a_r9_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_wr) |=> $stable(ctrl_q[CTRL_W-1:1]));

    a_r2_seen_with_low: assert property (@(posedge clk) disable iff (rst)
        $rose(start_seen) |-> $rose(sda_oe));
endmodule

// File: tb/i2c_start_seq_test.sv
module i2c_start_seq_test;
    logic       clk = 1'b0;
    logic       rst, tick, ctrl_wr, buf_wr;
    logic [4:0] ctrl_wdata;
    logic [6:0] reload;
    logic [7:0] buf_wdata;
    logic       sda_ext, scl_ext;
    logic [2:0] irq_clr;
    logic       sda_oe, start_seen, done_irq, bcol_irq, wcol_flag;
    logic [4:0] ctrl_q;
    logic [7:0] buf_q;
    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    i2c_start_seq uut (
        .clk(clk), .rst(rst), .tick(tick), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata), .reload(reload), .buf_wr(buf_wr),
        .buf_wdata(buf_wdata), .sda_in(sda_ext & ~sda_oe), .scl_in(scl_ext),
        .irq_clr(irq_clr), .sda_oe(sda_oe), .ctrl_q(ctrl_q),
        .start_seen(start_seen), .done_irq(done_irq), .bcol_irq(bcol_irq),
        .wcol_flag(wcol_flag), .buf_q(buf_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic int eff_n(input int r);
        return (r < 2) ? 1 : r;
    endfunction

    task automatic do_reset();
        rst = 1'b1; tick = 1'b0; ctrl_wr = 1'b0; buf_wr = 1'b0; irq_clr = '0;
        sda_ext = 1'b1; scl_ext = 1'b1; ctrl_wdata = '0; buf_wdata = '0;
        cyc(2);
        rst = 1'b0;
        cyc(3);
    endtask

    task automatic write_start(input int r);
        reload = 7'(r);
        ctrl_wr = 1'b1; ctrl_wdata = 5'b00001;
        cyc();
        ctrl_wr = 1'b0;
        cyc();
    endtask

    task automatic run_start(input int r, input int pct);
        int n = eff_n(r);
        int cnt = 0;
        int guard = 0;
        bit bad = 0;
        write_start(r);
        while (cnt < 2 * n && guard < 20000) begin
            tick = (($urandom % 100) < pct);
            cyc();
            if (tick) cnt++;
            guard++;
            if (sda_oe !== (cnt >= n) || start_seen !== (cnt >= n) ||
                done_irq !== (cnt >= 2 * n)) bad = 1;
            if (bad) break;
        end
        tick = 1'b0;
        chk($sformatf("R2/R3/R5 timing reload=%0d ticks=%0d", r, cnt),
            {sda_oe, start_seen, done_irq}, 3'b111);
        chk("R3 request cleared", ctrl_q[0], 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_tests++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        reload = '0;
        do_reset();
        chk("R1 reset outputs", {sda_oe, ctrl_q, start_seen, done_irq, bcol_irq, wcol_flag, buf_q}, '0);

        run_start(5, 100);
        tick = 1'b1;
        cyc(30);
        tick = 1'b0;
        chk("R4 hold after done", {sda_oe, start_seen, done_irq, bcol_irq}, 4'b1110);
        irq_clr = 3'b001; cyc(); irq_clr = '0;
        chk("R10 done cleared", done_irq, 1'b0);
        cyc(3);
        chk("R10 done stays clear", done_irq, 1'b0);

        do_reset(); run_start(0, 100);
        do_reset(); run_start(1, 60);
        for (int t = 0; t < 6; t++) begin
            do_reset();
            run_start(2 + int'($urandom % 18), 20 + int'($urandom % 80));
        end

        do_reset();
        buf_wr = 1'b1; buf_wdata = 8'hA5; cyc(); buf_wr = 1'b0;
        chk("R8 idle buffer write", {wcol_flag, buf_q}, {1'b0, 8'hA5});
        write_start(20);
        buf_wr = 1'b1; buf_wdata = 8'h3C; cyc(); buf_wr = 1'b0;
        chk("R8 busy buffer write refused", {wcol_flag, buf_q}, {1'b1, 8'hA5});
        ctrl_wr = 1'b1; ctrl_wdata = 5'b11110; cyc(); ctrl_wr = 1'b0;
        chk("R9 ctrl locked", ctrl_q, 5'b00001);
        irq_clr = 3'b100; cyc(); irq_clr = '0;
        chk("R10 wcol cleared", wcol_flag, 1'b0);

        scl_ext = 1'b0; cyc(4);
        chk("R7 scl low abort", {bcol_irq, sda_oe, ctrl_q[0], start_seen}, 4'b1000);
        scl_ext = 1'b1; cyc(3);
        tick = 1'b1; cyc(30); tick = 1'b0;
        chk("R7 no later start", {sda_oe, start_seen}, 2'b00);
        irq_clr = 3'b010; cyc(); irq_clr = '0;
        chk("R10 bcol cleared", bcol_irq, 1'b0);

        do_reset();
        sda_ext = 1'b0; scl_ext = 1'b0; cyc(3);
        write_start(4);
        chk("R6 both low", {bcol_irq, ctrl_q[0], sda_oe}, 3'b100);
        do_reset();
        sda_ext = 1'b0; cyc(3);
        write_start(4);
        tick = 1'b1; cyc(10); tick = 1'b0;
        chk("R6 sda low", {bcol_irq, ctrl_q[0], sda_oe, start_seen}, 4'b1000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule